// File: doc/BRIEF.md
# Parallel Add/Subtract Unit with Optional Saturation

This unit takes two signed two's-complement operands and, in one cycle, forms both their sum (A + B) and their difference (A - B). Each result is steered to one of two output ports by a swap control, so the caller decides which destination holds the sum and which holds the difference. A mode bit chooses between wrapping arithmetic and saturating arithmetic. In saturating mode, an overflowing result is clamped to the largest or smallest representable value.

Alongside the results, the unit produces a 4-bit status word that merges the conditions of both results: zero, negative, overflow and carry. Results and status are captured in registers on a rising clock edge while the valid strobe is high. With the strobe low they hold their values. A synchronous reset clears them.

Top module: `dual_addsub_alu`

## Requirements
- R1: In wrapping mode (sat_i=0), the sum output is (A+B) mod 2^W and the difference output is (A-B) mod 2^W. Example: A=0x7FFFFFFF and B=0x00000001 give 0x80000000 and 0x7FFFFFFE.
- R2: In saturating mode (sat_i=1), a result that overflows positively is clamped to 0x7FFFFFFF. A result that does not overflow equals its wrapped value. Example: A=0x7FFFFFFF and B=1 give a sum of 0x7FFFFFFF and a difference of 0x7FFFFFFE.
- R3: In saturating mode, a result that overflows negatively is clamped to 0x80000000. Example: A=0x80000000 and B=1 give a difference of 0x80000000.
- R4: When swap_i=0, res0_o receives the sum and res1_o receives the difference. When swap_i=1, the two are exchanged.
- R5: flags_o[2] (overflow) is 1 when either operation overflows in signed arithmetic. This holds in both modes.
- R6: flags_o[1] (negative) is the OR of the sign bits of the two stored results, taken after saturation.
- R7: flags_o[0] (zero) is 1 when either stored result equals zero.
- R8: flags_o[3] (carry) is the OR of two terms: the unsigned carry-out of A+B, and "no borrow" of A-B (A >= B unsigned).
- R9: A cycle with valid_i=0 leaves res0_o, res1_o and flags_o unchanged.
- R10: A synchronous reset (rst=1 at a rising edge) clears res0_o, res1_o and flags_o to zero.
- R11: The state of swap_i does not change flags_o, nor the set of two result values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Capture strobe for results and flags |
| sat_i | input | 1 | 1 selects saturating arithmetic, 0 selects wrapping |
| swap_i | input | 1 | 1 routes the difference to res0_o and the sum to res1_o |
| opa_i | input | W (32) | Operand A |
| opb_i | input | W (32) | Operand B |
| res0_o | output | W (32) | First destination result |
| res1_o | output | W (32) | Second destination result |
| flags_o | output | 4 | {carry, overflow, negative, zero} |

## Verification
The assertions assume that valid_i, sat_i and the operands are known and stable around each rising edge. They compare each registered value with the inputs of the cycle before. They also assume reset is held for at least one edge before any check applies. The bench changes inputs only on falling edges and keeps every control bit binary. Its random operands are weighted toward the signed limits, so that both overflow directions and zero results occur alongside ordinary values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic neg;
    logic zero;
  } alu_flags_t;

  // Largest positive or most negative value of a W-bit signed word
  function automatic logic [63:0] sat_limit(input int w, input logic neg_side);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w - 1) v[i] = ~neg_side;
      else if (i == w - 1) v[i] = neg_side;
    end
    return v;
  endfunction
endpackage

// File: rtl/addsub_lane.sv
module addsub_lane #(
  parameter int W      = 32,
  parameter bit IS_SUB = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         carry
);
  localparam int MSB = W - 1;

  logic [W:0]   ext;
  logic [W-1:0] b_eff;
  logic [W-1:0] raw;
  logic [W-1:0] clamp;

  assign b_eff = IS_SUB ? ~b : b;
  assign ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, IS_SUB};
  assign raw   = ext[W-1:0];
  // For the subtract lane a carry-out means no borrow
  assign carry = ext[W];

  generate
    if (IS_SUB) begin : g_sub_ovf
      assign ovf = (a[MSB] != b[MSB]) && (raw[MSB] != a[MSB]);
    end else begin : g_add_ovf
      assign ovf = (a[MSB] == b[MSB]) && (raw[MSB] != a[MSB]);
    end
  endgenerate

  // On overflow the true result has the sign of operand A
  assign clamp  = alu_pkg::sat_limit(W, a[MSB])[W-1:0];
  assign result = (sat && ovf) ? clamp : raw;
endmodule

// File: rtl/result_router.sv
module result_router #(
  parameter int W = 32
) (
  input  logic         swap,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] diff,
  output logic [W-1:0] dst0,
  output logic [W-1:0] dst1
);
  always_comb begin
    if (swap) begin
      dst0 = diff;
      dst1 = sum;
    end else begin
      dst0 = sum;
      dst1 = diff;
    end
  end
endmodule

// File: rtl/flag_merge.sv
module flag_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0]       sum,
  input  logic [W-1:0]       diff,
  input  logic               add_ovf,
  input  logic               sub_ovf,
  input  logic               add_carry,
  input  logic               sub_noborrow,
  output alu_pkg::alu_flags_t flags
);
  always_comb begin
    flags.zero  = (sum == '0) || (diff == '0);
    flags.neg   = sum[W-1] | diff[W-1];
    flags.ovf   = add_ovf | sub_ovf;
    flags.carry = add_carry | sub_noborrow;
  end
endmodule

// File: rtl/dual_addsub_alu.sv
module dual_addsub_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic         sat_i,
  input  logic         swap_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] res0_o,
  output logic [W-1:0] res1_o,
  output logic [3:0]   flags_o
);
  logic [W-1:0] sum_w, diff_w, dst0_w, dst1_w;
  logic         add_ovf_w, sub_ovf_w, add_carry_w, sub_nb_w;
  alu_pkg::alu_flags_t flags_w;

  addsub_lane #(.W(W), .IS_SUB(1'b0)) u_add (
    .a(opa_i), .b(opb_i), .sat(sat_i),
    .result(sum_w), .ovf(add_ovf_w), .carry(add_carry_w)
  );

  addsub_lane #(.W(W), .IS_SUB(1'b1)) u_sub (
    .a(opa_i), .b(opb_i), .sat(sat_i),
    .result(diff_w), .ovf(sub_ovf_w), .carry(sub_nb_w)
  );

  result_router #(.W(W)) u_route (
    .swap(swap_i), .sum(sum_w), .diff(diff_w),
    .dst0(dst0_w), .dst1(dst1_w)
  );

  flag_merge #(.W(W)) u_flags (
    .sum(sum_w), .diff(diff_w),
    .add_ovf(add_ovf_w), .sub_ovf(sub_ovf_w),
    .add_carry(add_carry_w), .sub_noborrow(sub_nb_w),
    .flags(flags_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res0_o  <= '0;
      res1_o  <= '0;
      flags_o <= '0;
    end else if (valid_i) begin
      res0_o  <= dst0_w;
      res1_o  <= dst1_w;
      flags_o <= flags_w;
    end
  end
endmodule

// File: rtl/dual_addsub_alu_chk.sv
module dual_addsub_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic         sat_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] res0_o,
  input logic [W-1:0] res1_o,
  input logic [3:0]   flags_o
);
  // R1
  wrap_pair_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !sat_i) |=> (W'(res0_o + res1_o) == W'($past(opa_i) << 1)));

  // R2
  sat_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sat_i) |=> (flags_o[2] || (W'(res0_o + res1_o) == W'($past(opa_i) << 1))));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (flags_o[1] == (res0_o[W-1] | res1_o[W-1])));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (flags_o[0] == ((res0_o == '0) || (res1_o == '0))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(res0_o) && $stable(res1_o) && $stable(flags_o)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res0_o == '0 && res1_o == '0 && flags_o == '0));
endmodule

bind dual_addsub_alu dual_addsub_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .sat_i(sat_i), .opa_i(opa_i),
  .res0_o(res0_o), .res1_o(res1_o), .flags_o(flags_o)
);

// File: tb/dual_addsub_alu_tb.sv
module dual_addsub_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        valid_i = 0, sat_i = 0, swap_i = 0;
  logic [31:0] opa_i = 0, opb_i = 0;
  logic [31:0] res0_o, res1_o;
  logic [3:0]  flags_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_addsub_alu u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .sat_i(sat_i), .swap_i(swap_i),
    .opa_i(opa_i), .opb_i(opb_i), .res0_o(res0_o), .res1_o(res1_o), .flags_o(flags_o)
  );

  // Reference: exact signed arithmetic in 64 bits, then clamp or wrap
  function automatic logic [31:0] ref_val(input logic [31:0] a, input logic [31:0] b,
                                          input bit sub, input bit sat, output bit ovf);
    longint t;
    t = sub ? (longint'($signed(a)) - longint'($signed(b)))
            : (longint'($signed(a)) + longint'($signed(b)));
    ovf = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    if (sat && t > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (sat && t < -64'sd2147483648) return 32'h8000_0000;
    return t[31:0];
  endfunction

  task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input bit sat, input bit swp);
    @(negedge clk);
    opa_i = a; opb_i = b; sat_i = sat; swap_i = swp; valid_i = 1;
    @(negedge clk);
    valid_i = 0;
  endtask

  task automatic check_op(input logic [31:0] a, input logic [31:0] b, input bit sat, input bit swp, input string req);
    logic [31:0] s, d, e0, e1;
    bit ao, so;
    logic [3:0] ef;
    apply(a, b, sat, swp);
    s = ref_val(a, b, 0, sat, ao);
    d = ref_val(a, b, 1, sat, so);
    e0 = swp ? d : s;
    e1 = swp ? s : d;
    ef[0] = (s == 0) || (d == 0);
    ef[1] = s[31] | d[31];
    ef[2] = ao | so;
    ef[3] = ({1'b0, a} + {1'b0, b}) > 33'h0_FFFF_FFFF || (a >= b);
    chk(req, res0_o == e0, {32'h0, res0_o}, {32'h0, e0});
    chk(req, res1_o == e1, {32'h0, res1_o}, {32'h0, e1});
    chk(req, flags_o == ef, {60'h0, flags_o}, {60'h0, ef});
  endtask

  function automatic logic [31:0] pick(input int unsigned r);
    case (r % 6)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0000_0001;
      3: return 32'h0000_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst = 0;
    // R10: reset state
    chk("R10", res0_o == 0 && res1_o == 0 && flags_o == 0, {res0_o, res1_o}, 64'h0);

    // R1, R5, R6, R8: wrapping positive overflow
    check_op(32'h7FFF_FFFF, 32'h1, 0, 0, "R1");
    chk("R5", flags_o[2] == 1, flags_o[2], 1);
    chk("R6", flags_o[1] == 1, flags_o[1], 1);
    chk("R8", flags_o[3] == 1, flags_o[3], 1);
    // R11: swapped, same flags
    check_op(32'h7FFF_FFFF, 32'h1, 0, 1, "R11");
    chk("R4", res0_o == 32'h7FFF_FFFE && res1_o == 32'h8000_0000, {res0_o, res1_o}, 64'h7FFFFFFE_80000000);
    // R2: saturating positive clamp
    check_op(32'h7FFF_FFFF, 32'h1, 1, 0, "R2");
    chk("R6", flags_o[1] == 0, flags_o[1], 0);
    chk("R5", flags_o[2] == 1, flags_o[2], 1);
    check_op(32'h7FFF_FFFF, 32'h1, 1, 1, "R11");
    // R3: negative clamp
    check_op(32'h8000_0000, 32'h1, 1, 0, "R3");
    chk("R3", res1_o == 32'h8000_0000, res1_o, 64'h8000_0000);
    check_op(32'h8000_0000, 32'h8000_0000, 1, 1, "R3");
    // R7: zero results
    check_op(32'h5, 32'h5, 0, 0, "R7");
    chk("R7", flags_o[0] == 1, flags_o[0], 1);
    check_op(32'h0, 32'h0, 1, 1, "R7");
    // R8: borrow, no add carry
    check_op(32'h1, 32'h2, 0, 0, "R8");
    chk("R8", flags_o[3] == 0, flags_o[3], 0);

    // R9: hold while valid low
    begin
      logic [31:0] h0, h1; logic [3:0] hf;
      h0 = res0_o; h1 = res1_o; hf = flags_o;
      @(negedge clk);
      opa_i = 32'h1234_5678; opb_i = 32'h8765_4321; sat_i = 1; swap_i = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R9", res0_o == h0 && res1_o == h1 && flags_o == hf, {res0_o, res1_o}, {h0, h1});
    end

    // Random mix across R1..R8, R11
    for (int i = 0; i < 400; i++) begin
      check_op(pick($urandom()), pick($urandom()), 1'($urandom() & 1), 1'($urandom() & 1), "R1");
    end

    // R10: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", res0_o == 0 && res1_o == 0 && flags_o == 0, {res0_o, res1_o}, 64'h0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule